// File: doc/BRIEF.md
# Three-Ones Serial Run Detector

This block watches a serial bit stream, taking one bit on every rising clock edge. It raises a single-cycle flag once three 1s in a row have arrived. It is a Moore machine, so the flag depends only on the current state. The flag therefore shows in the cycle after the edge that sampled the third 1.

Detection does not overlap. After a hit, the machine goes back to its start state on the next edge whatever the input is. The bit sampled on that edge is discarded, so a run of five 1s reports once.

The 2-bit state register is brought out on a port so that surrounding logic and checkers can observe it. A synchronous active-high reset returns the machine to its start state.

Top module: `run3_detector`

States, with their binary codes on `state_q`:
- `ST_IDLE` (00): start state, no 1 counted.
- `ST_ONE` (01): one 1 seen.
- `ST_TWO` (10): two 1s in a row seen.
- `ST_HIT` (11): three 1s seen. `found` is high only in this state.

Transitions:
- idle-advance: `ST_IDLE` goes to `ST_ONE` on a 1.
- idle-hold: `ST_IDLE` stays in `ST_IDLE` on a 0.
- one-advance: `ST_ONE` goes to `ST_TWO` on a 1.
- two-advance: `ST_TWO` goes to `ST_HIT` on a 1.
- zero-clear: `ST_ONE` or `ST_TWO` goes to `ST_IDLE` on a 0.
- hit-return: `ST_HIT` goes to `ST_IDLE` on any input.

## Requirements
- R1: When `rst` is high at a rising edge, `state_q` becomes 00 and `found` is 0 after that edge, whatever `bit_in` is.
- R2: In state 00, a 1 on `bit_in` moves `state_q` to 01, and a 0 keeps it at 00.
- R3: In state 01, a 1 moves `state_q` to 10.
- R4: In state 10, a 1 moves `state_q` to 11.
- R5: In states 01 or 10, a 0 moves `state_q` to 00.
- R6: From state 11, `state_q` goes to 00 on the next edge for either value of `bit_in`.
- R7: `found` is 1 exactly when `state_q` is 11, which is the cycle after the edge that sampled the third consecutive 1. It is 0 in every other state.
- R8: Five consecutive 1s starting from state 00 produce exactly one `found` pulse, because the bit sampled in state 11 is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial input bit, sampled on each rising edge |
| found | output | 1 | High for one cycle while the machine is in state 11 |
| state_q | output | 2 | Current state code (00, 01, 10, 11) |

## Verification
The block has no tunable parameters; its state width is fixed at two bits in the package. A single build therefore reaches all four states and all six transitions. The bench drives runs of one, two, three and five 1s, broken by 0s at each depth. It also asserts reset while the machine is part-way through a run and while it sits in the detect state, so the non-overlap rule and the reset priority are both exercised against the exposed state code.

// File: rtl/run3_pkg.sv
package run3_pkg;

    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 2'b00,
        ST_ONE  = 2'b01,
        ST_TWO  = 2'b10,
        ST_HIT  = 2'b11
    } run_state_t;

endpackage

// File: rtl/run3_next.sv
module run3_next
    import run3_pkg::*;
(
    input  run_state_t cur,
    input  logic       bit_in,
    output run_state_t nxt
);

    always_comb begin
        nxt = ST_IDLE;
        unique case (cur)
            ST_IDLE: nxt = bit_in ? ST_ONE : ST_IDLE;
            ST_ONE:  nxt = bit_in ? ST_TWO : ST_IDLE;
            ST_TWO:  nxt = bit_in ? ST_HIT : ST_IDLE;
            ST_HIT:  nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/run3_decode.sv
module run3_decode
    import run3_pkg::*;
(
    input  run_state_t cur,
    output logic       found
);

    always_comb begin
        found = 1'b0;
        unique case (cur)
            ST_HIT:  found = 1'b1;
            ST_IDLE,
            ST_ONE,
            ST_TWO:  found = 1'b0;
        endcase
    end

endmodule

// File: rtl/run3_detector.sv
module run3_detector
    import run3_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_in,
    output logic               found,
    output logic [STATE_W-1:0] state_q
);

    run_state_t cur_q;
    run_state_t nxt_s;

    run3_next u_next (
        .cur    (cur_q),
        .bit_in (bit_in),
        .nxt    (nxt_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= ST_IDLE;
        end else begin
            cur_q <= nxt_s;
        end
    end

    run3_decode u_decode (
        .cur   (cur_q),
        .found (found)
    );

    assign state_q = cur_q;

    // R2: a 1 in the start state advances to one-seen
    p_idle_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == 2'b00 && bit_in) |=> state_q == 2'b01);

    // R4: a 1 after two ones reaches the detect state
    p_two_advance_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == 2'b10 && bit_in) |=> state_q == 2'b11);

    // R5: a 0 below the detect state clears the run
    p_zero_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q != 2'b11 && !bit_in) |=> state_q == 2'b00);

    // R6: detect always returns to start
    p_hit_return_r6: assert property (@(posedge clk) disable iff (rst)
        state_q == 2'b11 |=> state_q == 2'b00);

    // R7: a flag is always caused by a 1 arriving in the two-seen state
    p_found_cause_r7: assert property (@(posedge clk) disable iff (rst)
        found |-> ($past(state_q) == 2'b10 && $past(bit_in)));

    // R8: never two flags in successive cycles
    p_no_back_to_back_r8: assert property (@(posedge clk) disable iff (rst)
        found |=> !found);

endmodule

// File: tb/test_run3_detector.sv
module test_run3_detector;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_in = 1'b0;
    logic       found;
    logic [1:0] state_q;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    run3_detector i_run3_detector (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (bit_in),
        .found   (found),
        .state_q (state_q)
    );

    localparam int VEC_N = 16;
    // {bit_in, expected state after the edge, expected found}
    localparam logic [3:0] VEC [VEC_N] = '{
        {1'b1, 2'b01, 1'b0},
        {1'b1, 2'b10, 1'b0},
        {1'b1, 2'b11, 1'b1},
        {1'b1, 2'b00, 1'b0},
        {1'b1, 2'b01, 1'b0},
        {1'b0, 2'b00, 1'b0},
        {1'b0, 2'b00, 1'b0},
        {1'b1, 2'b01, 1'b0},
        {1'b1, 2'b10, 1'b0},
        {1'b0, 2'b00, 1'b0},
        {1'b1, 2'b01, 1'b0},
        {1'b1, 2'b10, 1'b0},
        {1'b1, 2'b11, 1'b1},
        {1'b0, 2'b00, 1'b0},
        {1'b1, 2'b01, 1'b0},
        {1'b0, 2'b00, 1'b0}
    };
    string vec_tag [VEC_N] = '{
        "R2", "R3", "R4 R7", "R6", "R8", "R5", "R2", "R2",
        "R3", "R5", "R2", "R3", "R4 R7", "R6", "R2", "R5"
    };

    task automatic check(input logic [1:0] es, input logic ef, input string tag);
        checks++;
        if (state_q !== es || found !== ef) begin
            errors++;
            $display("FAIL %s: state=%b found=%b expected state=%b found=%b",
                     tag, state_q, found, es, ef);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, sample at the next fall
    task automatic step(input logic b);
        bit_in = b;
        @(negedge clk);
    endtask

    initial begin
        int pulses;
        @(negedge clk);
        bit_in = 1'b1;
        @(negedge clk);
        check(2'b00, 1'b0, "R1 reset state");
        rst = 1'b0;

        for (int i = 0; i < VEC_N; i++) begin
            step(VEC[i][3]);
            check(VEC[i][2:1], VEC[i][0], vec_tag[i]);
        end

        // R8: five ones from start give one pulse
        pulses = 0;
        for (int i = 0; i < 5; i++) begin
            step(1'b1);
            if (found) pulses++;
        end
        checks++;
        if (pulses != 1) begin
            errors++;
            $display("FAIL R8: pulses=%0d expected=1", pulses);
        end
        // machine is at 01 after the fifth one; clear it
        step(1'b0);
        check(2'b00, 1'b0, "R5 after run");

        // R1: reset part-way through a run
        step(1'b1);
        step(1'b1);
        check(2'b10, 1'b0, "R3 before reset");
        rst = 1'b1;
        step(1'b1);
        check(2'b00, 1'b0, "R1 reset mid-run");
        rst = 1'b0;

        // R1: reset while in the detect state
        step(1'b1);
        step(1'b1);
        step(1'b1);
        check(2'b11, 1'b1, "R7 detect before reset");
        rst = 1'b1;
        step(1'b1);
        check(2'b00, 1'b0, "R1 reset from detect");
        rst = 1'b0;

        // R6: detect returns to start on a 0 as well
        step(1'b1);
        step(1'b1);
        step(1'b1);
        step(1'b0);
        check(2'b00, 1'b0, "R6 return on zero");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule